// File: doc/BRIEF.md
# Serial Configuration EEPROM Boot Reader

This block brings up a board from a small three-wire serial EEPROM that holds 16-bit words. It drives chip select, the shift clock and the serial data line into the memory, and it samples the memory's serial output. After reset it first works out whether the attached part takes a 6-bit or an 8-bit word address. It then reads the first 64 words in order, keeping a 16-bit running sum. The first three words become a 48-bit station address. The address is published only when the sum of the whole image matches a fixed signature.

When the boot scan has finished, a host can fetch any single word with a request/address pulse. The word comes back on a one-cycle valid strobe. Every serial access is paced by a parameterised half-period divider, so the shift clock can be held within the memory's timing limit at any system clock rate. Only reads are issued.

Top module: `mw_eeprom_reader`

## Requirements
- R1: Each access holds `ee_cs` low for one full step of HALF_DIV clocks before raising it, and the shift clock is low whenever `ee_cs` is low. `ee_cs` returns low after the last data bit.
- R2: The command is a 13-bit frame sent MSB first: leading zeros, a start bit of 1, the read opcode bits 1 then 0, and then the word address. For 6-bit addressing the frame is {4'b0000, 3'b110, addr[5:0]}. For 8-bit addressing it is {2'b00, 3'b110, addr[7:0]}.
- R3: `ee_di` is set up while `ee_sk` is low and does not change while `ee_sk` is high.
- R4: After the command, 16 data bits are taken MSB first, each sampled while `ee_sk` is high. An access therefore has exactly 29 rising edges of `ee_sk`.
- R5: Every high and low phase of `ee_sk` lasts exactly HALF_DIV system clocks.
- R6: The block first reads word 0 with the 6-bit frame. It selects 8-bit addressing for all later accesses if that word is 16'hFFFF, and 6-bit addressing otherwise.
- R7: Words 0 to 63 are summed modulo 2^16. `csum_ok` is 1 after the scan exactly when the sum equals 16'hBABA.
- R8: `station_addr` bits [16k+15:16k] hold word k for k = 0..2, so the low byte of word 0 is octet 0 at bits [7:0]. The address is all zeros whenever the checksum fails, and before the scan ends.
- R9: `boot_done`, `csum_ok` and `station_addr` are 0 after reset. `boot_done` rises when the scan ends and stays high until the next reset.
- R10: After the scan, a `host_req` pulse with `host_addr` reads that word using the detected width; in 6-bit mode `host_addr[7:6]` are ignored. The word is returned on `host_data` with a one-cycle `host_valid` pulse.
- R11: `host_req` is ignored while the boot scan runs and while a host read is in progress; no `host_valid` results from such a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ee_cs | output | 1 | EEPROM chip select, active high |
| ee_sk | output | 1 | EEPROM shift clock |
| ee_di | output | 1 | Serial data into the EEPROM |
| ee_do | input | 1 | Serial data out of the EEPROM |
| host_req | input | 1 | Single-word read request pulse |
| host_addr | input | 8 | Word address for the host read |
| host_valid | output | 1 | One-cycle strobe marking `host_data` |
| host_data | output | 16 | Word returned to the host |
| boot_done | output | 1 | Boot scan finished |
| csum_ok | output | 1 | Image sum matched the signature |
| station_addr | output | 48 | Station address, zero unless the checksum passed |

## Verification
Three images are used. The first is a valid image on a 6-bit part. The second is the same image with one word flipped, which shows that the signature check and the zeroing of the address depend on the whole image and not only on the first three words. The third is an 8-bit part whose word 0 is all ones. It reads back as 16'hFFFF through the short frame and forces the wide mode, and the captured frame of a later host read shows which command format was chosen. Host reads with out-of-range upper address bits and requests made during the scan or during another read separate correct address masking and request gating from a reader that acts on every pulse.

// File: rtl/mw_pkg.sv
package mw_pkg;
  localparam int WADDR_W = 8;
  localparam int WORD_W  = 16;
  localparam int FRAME_W = 13;

  typedef enum logic [3:0] {
    X_IDLE, X_DESEL, X_SEL, X_CLO, X_CHI, X_GAP, X_DHI, X_DLO, X_END
  } xfer_st_e;

  typedef enum logic [2:0] {
    T_DET_GO, T_DET_WAIT, T_SCAN_GO, T_SCAN_WAIT, T_READY, T_HOST_WAIT
  } top_st_e;

  // start bit plus read opcode, then the word address, zero padded in front
  function automatic logic [FRAME_W-1:0] mk_frame(input logic [WADDR_W-1:0] a,
                                                  input logic wide);
    mk_frame = wide ? {2'b00, 3'b110, a} : {4'b0000, 3'b110, a[5:0]};
  endfunction
endpackage

// File: rtl/mw_halfstep.sv
module mw_halfstep #(
  parameter int HALF_DIV = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = !clr && (cnt_q == CW'(HALF_DIV - 1));

  always_comb begin
    if (clr || tick) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  generate
    if (HALF_DIV > 1) begin : g_gap
      // R5: two step boundaries never fall in adjacent cycles
      p_tick_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/mw_word_xfer.sv
module mw_word_xfer
  import mw_pkg::*;
#(
  parameter int HALF_DIV = 200
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [WADDR_W-1:0] addr,
  input  logic               wide,
  input  logic               ee_do,
  output logic               ee_cs,
  output logic               ee_sk,
  output logic               ee_di,
  output logic               done,
  output logic [WORD_W-1:0]  word
);
  xfer_st_e            st_q, st_d;
  logic [FRAME_W-1:0]  fr_q, fr_d;
  logic [3:0]          bn_q, bn_d;
  logic [WORD_W-1:0]   sh_q, sh_d;
  logic                done_q, done_d;
  logic                tick;

  mw_halfstep #(.HALF_DIV(HALF_DIV)) i_step (
    .clk(clk), .rst_n(rst_n), .clr(st_q == X_IDLE), .tick(tick)
  );

  assign ee_cs = !(st_q inside {X_IDLE, X_DESEL, X_END});
  assign ee_sk = (st_q == X_CHI) || (st_q == X_DHI);
  assign ee_di = ((st_q == X_CLO) || (st_q == X_CHI)) && fr_q[bn_q];
  assign done  = done_q;
  assign word  = sh_q;

  always_comb begin
    st_d   = st_q;
    fr_d   = fr_q;
    bn_d   = bn_q;
    sh_d   = sh_q;
    done_d = 1'b0;
    case (st_q)
      X_IDLE:  if (start) begin fr_d = mk_frame(addr, wide); st_d = X_DESEL; end
      X_DESEL: if (tick) st_d = X_SEL;
      X_SEL:   if (tick) begin bn_d = 4'(FRAME_W - 1); st_d = X_CLO; end
      X_CLO:   if (tick) st_d = X_CHI;
      X_CHI:   if (tick) begin
                 if (bn_q == 4'd0) st_d = X_GAP;
                 else begin bn_d = bn_q - 1'b1; st_d = X_CLO; end
               end
      X_GAP:   if (tick) begin bn_d = 4'(WORD_W - 1); st_d = X_DHI; end
      X_DHI:   if (tick) begin sh_d = {sh_q[WORD_W-2:0], ee_do}; st_d = X_DLO; end
      X_DLO:   if (tick) begin
                 if (bn_q == 4'd0) st_d = X_END;
                 else begin bn_d = bn_q - 1'b1; st_d = X_DHI; end
               end
      X_END:   if (tick) begin st_d = X_IDLE; done_d = 1'b1; end
      default: st_d = X_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= X_IDLE;
      fr_q   <= '0;
      bn_q   <= '0;
      sh_q   <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      fr_q   <= fr_d;
      bn_q   <= bn_d;
      sh_q   <= sh_d;
      done_q <= done_d;
    end
  end

  p_sk_needs_cs_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ee_cs |-> !ee_sk);
  p_cs_rise_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ee_cs) |-> (!ee_sk && !ee_di));
  p_di_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_sk && $past(ee_sk)) |-> $stable(ee_di));
endmodule

// File: rtl/mw_eeprom_reader.sv
module mw_eeprom_reader
  import mw_pkg::*;
#(
  parameter int          HALF_DIV  = 200,
  parameter int          NUM_WORDS = 64,
  parameter int          ID_WORDS  = 3,
  parameter logic [15:0] SIGNATURE = 16'hBABA
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic        ee_cs,
  output logic        ee_sk,
  output logic        ee_di,
  input  logic        ee_do,
  input  logic        host_req,
  input  logic [7:0]  host_addr,
  output logic        host_valid,
  output logic [15:0] host_data,
  output logic        boot_done,
  output logic        csum_ok,
  output logic [47:0] station_addr
);
  localparam int IX_W = $clog2(NUM_WORDS);
  localparam int ID_W = (ID_WORDS > 1) ? $clog2(ID_WORDS) : 1;
  localparam int ST_W = WORD_W * ID_WORDS;

  top_st_e                          st_q, st_d;
  logic                             wide_q, wide_d;
  logic [IX_W-1:0]                  ix_q, ix_d;
  logic [WORD_W-1:0]                sum_q, sum_d, sum_nx;
  logic [ID_WORDS-1:0][WORD_W-1:0]  idw_q, idw_d;
  logic                             bd_q, bd_d, ok_q, ok_d, hv_q, hv_d;
  logic [WORD_W-1:0]                hd_q, hd_d;
  logic [ST_W-1:0]                  stn_q, stn_d;

  logic               x_start, x_wide, x_done;
  logic [WADDR_W-1:0] x_addr;
  logic [WORD_W-1:0]  x_word;

  mw_word_xfer #(.HALF_DIV(HALF_DIV)) i_xfer (
    .clk(clk), .rst_n(rst_n), .start(x_start), .addr(x_addr), .wide(x_wide),
    .ee_do(ee_do), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di),
    .done(x_done), .word(x_word)
  );

  assign sum_nx = sum_q + x_word;

  always_comb begin
    st_d = st_q; wide_d = wide_q; ix_d = ix_q; sum_d = sum_q; idw_d = idw_q;
    bd_d = bd_q; ok_d = ok_q; stn_d = stn_q; hv_d = 1'b0; hd_d = hd_q;
    x_start = 1'b0; x_addr = '0; x_wide = wide_q;
    case (st_q)
      T_DET_GO: begin x_start = 1'b1; x_wide = 1'b0; st_d = T_DET_WAIT; end
      T_DET_WAIT: if (x_done) begin
        wide_d = (x_word == 16'hFFFF);
        st_d   = T_SCAN_GO;
      end
      T_SCAN_GO: begin
        x_start = 1'b1; x_addr = WADDR_W'(ix_q); st_d = T_SCAN_WAIT;
      end
      T_SCAN_WAIT: if (x_done) begin
        sum_d = sum_nx;
        if (ix_q < IX_W'(ID_WORDS)) idw_d[ID_W'(ix_q)] = x_word;
        if (ix_q == IX_W'(NUM_WORDS - 1)) begin
          bd_d  = 1'b1;
          ok_d  = (sum_nx == SIGNATURE);
          stn_d = (sum_nx == SIGNATURE) ? idw_d : '0;
          st_d  = T_READY;
        end else begin
          ix_d = ix_q + 1'b1;
          st_d = T_SCAN_GO;
        end
      end
      T_READY: if (host_req) begin
        x_start = 1'b1;
        x_addr  = wide_q ? host_addr : {2'b00, host_addr[5:0]};
        st_d    = T_HOST_WAIT;
      end
      T_HOST_WAIT: if (x_done) begin hv_d = 1'b1; hd_d = x_word; st_d = T_READY; end
      default: st_d = T_DET_GO;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= T_DET_GO; wide_q <= 1'b0; ix_q <= '0; sum_q <= '0; idw_q <= '0;
      bd_q <= 1'b0; ok_q <= 1'b0; stn_q <= '0; hv_q <= 1'b0; hd_q <= '0;
    end else begin
      st_q <= st_d; wide_q <= wide_d; ix_q <= ix_d; sum_q <= sum_d; idw_q <= idw_d;
      bd_q <= bd_d; ok_q <= ok_d; stn_q <= stn_d; hv_q <= hv_d; hd_q <= hd_d;
    end
  end

  assign boot_done    = bd_q;
  assign csum_ok      = ok_q;
  assign station_addr = 48'(stn_q);
  assign host_valid   = hv_q;
  assign host_data    = hd_q;

  p_valid_after_boot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    host_valid |-> boot_done);
  p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(boot_done) |-> boot_done);
  p_addr_zero_bad_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !csum_ok |-> (station_addr == 48'h0));
  p_valid_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    host_valid |=> !host_valid);
endmodule

// File: tb/test_mw_eeprom_reader.sv
module test_mw_eeprom_reader;
  localparam int HD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ee_cs, ee_sk, ee_di;
  logic ee_do = 1'b1;
  logic host_req = 1'b0;
  logic [7:0] host_addr = '0;
  logic host_valid, boot_done, csum_ok;
  logic [15:0] host_data;
  logic [47:0] station_addr;

  always #2.5 clk = ~clk;

  mw_eeprom_reader #(.HALF_DIV(HD)) i_mw_eeprom_reader (
    .clk(clk), .rst_n(rst_n), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di),
    .ee_do(ee_do), .host_req(host_req), .host_addr(host_addr),
    .host_valid(host_valid), .host_data(host_data), .boot_done(boot_done),
    .csum_ok(csum_ok), .station_addr(station_addr)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // behavioural serial EEPROM, width chosen by m_aw
  logic [15:0] mem [256];
  int          m_aw = 6;
  int          mst, mcnt, mk, nbit;
  logic [7:0]  maddr;
  logic [12:0] last_frame;

  always @(posedge ee_cs) begin
    mst = 0; nbit = 0; ee_do <= 1'b1;
  end

  always @(posedge ee_sk) if (ee_cs) begin
    if (nbit < 13) begin last_frame = {last_frame[11:0], ee_di}; nbit++; end
    case (mst)
      0: if (ee_di) begin mst = 1; mcnt = 0; end
      1: begin mcnt++; if (mcnt == 2) begin mst = 2; mcnt = 0; maddr = '0; end end
      2: begin
        maddr = {maddr[6:0], ee_di}; mcnt++;
        if (mcnt == m_aw) begin mst = 3; mk = 0; end
      end
      default: begin
        if (mk < 16) ee_do <= mem[maddr][15-mk]; else ee_do <= 1'b1;
        mk++;
      end
    endcase
  end

  // pin protocol monitor
  int  hi_run = 0, lo_cs_run = 0, rises = 0;
  int  err_r1 = 0, err_r3 = 0, err_r4 = 0, err_r5 = 0;
  logic p_sk = 0, p_di = 0, p_cs = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (ee_sk && p_sk && ee_di != p_di) err_r3++;
      if (ee_sk) hi_run++;
      if (p_sk && !ee_sk) begin if (hi_run != HD) err_r5++; hi_run = 0; end
      if (ee_sk && !p_sk) rises++;
      if (!ee_cs) lo_cs_run++;
      if (ee_cs && !p_cs) begin if (lo_cs_run < HD) err_r1++; lo_cs_run = 0; rises = 0; end
      if (!ee_cs && p_cs) begin if (rises != 29) err_r4++; end
      if (!ee_cs && ee_sk) err_r1++;
    end
    p_sk = ee_sk; p_di = ee_di; p_cs = ee_cs;
  end

  // scoreboard
  logic [15:0] expq[$];
  always @(negedge clk) if (rst_n && host_valid) begin
    if (expq.size() == 0) chk(1'b0, "R11 unexpected host_valid", {48'h0, host_data}, 64'h0);
    else begin
      logic [15:0] e;
      e = expq.pop_front();
      chk(host_data == e, "R10 host word", {48'h0, host_data}, {48'h0, e});
    end
  end

  task automatic fill(input logic [15:0] seed, input bit w0ones);
    logic [15:0] s;
    s = '0;
    for (int i = 0; i < 256; i++) mem[i] = 16'(i * 16'h1357) + seed;
    if (w0ones) mem[0] = 16'hFFFF;
    for (int i = 0; i < 63; i++) s = s + mem[i];
    mem[63] = 16'hBABA - s;
  endtask

  task automatic boot(input int aw);
    @(negedge clk) rst_n = 1'b0; m_aw = aw;
    repeat (4) @(negedge clk);
    chk(boot_done == 0, "R9 reset boot_done", {63'h0, boot_done}, 0);
    chk(csum_ok == 0, "R9 reset csum_ok", {63'h0, csum_ok}, 0);
    chk(station_addr == 0, "R9 reset station", {16'h0, station_addr}, 0);
    chk(ee_cs == 0 && host_valid == 0, "R1 reset pins", {62'h0, ee_cs, host_valid}, 0);
    rst_n = 1'b1;
    repeat (600) @(negedge clk);
    host_req = 1'b1; host_addr = 8'd4;   // R11: ignored during scan
    @(negedge clk) host_req = 1'b0;
    while (!boot_done) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  task automatic host_read(input logic [7:0] a, input logic [15:0] exp, input bit extra);
    @(negedge clk) host_req = 1'b1; host_addr = a; expq.push_back(exp);
    @(negedge clk) host_req = 1'b0;
    if (extra) begin  // R11: second request while busy
      repeat (20) @(negedge clk);
      host_req = 1'b1; host_addr = 8'd7;
      @(negedge clk) host_req = 1'b0;
    end
    while (expq.size() != 0) @(negedge clk);
    repeat (300) @(negedge clk);
  endtask

  bit finished = 0;

  initial begin
    // image A: 6-bit part, valid image
    fill(16'h0A0B, 1'b0);
    boot(6);
    chk(csum_ok == 1, "R7 good image csum", {63'h0, csum_ok}, 1);
    chk(station_addr == {mem[2], mem[1], mem[0]}, "R8 station order",
        {16'h0, station_addr}, {16'h0, mem[2], mem[1], mem[0]});
    host_read(8'd5, mem[5], 1'b1);
    chk(last_frame == {4'b0000, 3'b110, 6'd7} || last_frame == {4'b0000, 3'b110, 6'd5},
        "R2 6-bit frame", {51'h0, last_frame}, {51'h0, 4'b0000, 3'b110, 6'd5});
    chk(last_frame == {4'b0000, 3'b110, 6'd5}, "R11 busy request dropped",
        {51'h0, last_frame}, {51'h0, 4'b0000, 3'b110, 6'd5});
    host_read(8'hC5, mem[5], 1'b0);   // R10 upper bits ignored in 6-bit mode
    host_read(8'd63, mem[63], 1'b0);
    chk(last_frame == {4'b0000, 3'b110, 6'd63}, "R6 narrow mode kept",
        {51'h0, last_frame}, {51'h0, 4'b0000, 3'b110, 6'd63});

    // image B: one word corrupted
    fill(16'h0A0B, 1'b0);
    mem[10] = mem[10] ^ 16'h0001;
    boot(6);
    chk(boot_done == 1, "R9 done on bad image", {63'h0, boot_done}, 1);
    chk(csum_ok == 0, "R7 bad image csum", {63'h0, csum_ok}, 0);
    chk(station_addr == 0, "R8 station zeroed", {16'h0, station_addr}, 0);

    // image C: 8-bit part, word 0 all ones
    fill(16'h2468, 1'b1);
    boot(8);
    chk(csum_ok == 1, "R6 wide image csum", {63'h0, csum_ok}, 1);
    chk(station_addr == {mem[2], mem[1], 16'hFFFF}, "R8 wide station",
        {16'h0, station_addr}, {16'h0, mem[2], mem[1], 16'hFFFF});
    host_read(8'd200, mem[200], 1'b0);
    chk(last_frame == {2'b00, 3'b110, 8'd200}, "R6 wide frame",
        {51'h0, last_frame}, {51'h0, 2'b00, 3'b110, 8'd200});

    chk(err_r1 == 0, "R1 select framing", err_r1, 0);
    chk(err_r3 == 0, "R3 data stable in high phase", err_r3, 0);
    chk(err_r4 == 0, "R4 29 clocks per access", err_r4, 0);
    chk(err_r5 == 0, "R5 half period", err_r5, 0);
    chk(expq.size() == 0, "R10 queue drained", expq.size(), 0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog R9 actual timeout expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule